// File: doc/BRIEF.md
# Selectable-Clock Timer with Capture

A 16-bit timer/counter for a microcontroller peripheral set. Its count strobe comes from one of eight sources chosen by a 3-bit select: seven binary-divided rates of the 4 MHz system clock, produced as single-cycle enable strobes rather than gated clocks, or the rising edges of an asynchronous comparator output. The comparator output first passes through a two-stage synchronizer and an edge detector.

In timer mode the counter counts up. When it overflows from all ones, it reloads the value software last wrote and emits a one-cycle event pulse toward the interrupt flag logic, where that pulse sets the timer flag. In capture mode the counter keeps running, and each synchronized comparator rising edge copies the running count into a capture register and emits the event pulse. Software loads the count through a low-byte write, which is held in a buffer, followed by a high-byte write that commits all 16 bits. Reading the low byte latches the high byte of the selected value into a shadow register, so a 16-bit read made low byte first is coherent.

Top module: `sel_clk_timer`

## Requirements
- R1: After reset the count, reload value, capture value, low-byte buffer and high-byte shadow are all zero, so `val_lo`, `val_hi` and `tmr_evt` read 0.
- R2: The select codes 0 to 6 pick 4 MHz, 2 MHz, 1 MHz, 500 kHz, 250 kHz, 125 kHz and 62.5 kHz, so a count step happens every 2^code clock cycles. The first step falls on the 2^code-th rising edge after `run_en` goes high. Code 7 steps the count on each synchronized comparator rising edge.
- R3: In timer mode, a count step taken while the count is 0xFFFF loads the reload value instead. `tmr_evt` is high for exactly the one cycle after that edge.
- R4: In capture mode, a synchronized comparator rising edge copies the count as it was before that edge into the capture register and pulses `tmr_evt` for one cycle. An overflow in capture mode reloads the count but gives no event.
- R5: While `run_en` is low the count and capture value do not change except through a write, `tmr_evt` stays low, and the rate divider restarts from zero.
- R6: `wr_lo` only stores `wr_data` in a buffer and leaves the count unchanged. `wr_hi` loads {`wr_data`, buffer} into both the count and the reload value, and it takes precedence over a count step in the same cycle.
- R7: `val_lo` shows the low byte of the count in timer mode (`cap_mode` = 0) and the low byte of the capture value in capture mode (`cap_mode` = 1).
- R8: A `rd_lo` pulse latches the high byte of the value selected as in R7 into `val_hi`. Without `rd_lo`, `val_hi` holds its value.
- R9: A comparator rising edge, applied before clock edge 1, takes effect (count step or capture, and `tmr_evt`) at clock edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Block enable bit |
| clk_sel | input | 3 | Count source select, codes 0..7 |
| cap_mode | input | 1 | 0 timer mode, 1 capture mode |
| cmp_in | input | 1 | Asynchronous comparator output |
| wr_lo | input | 1 | Write strobe, low byte buffer |
| wr_hi | input | 1 | Write strobe, high byte and commit |
| wr_data | input | 8 | Write data |
| rd_lo | input | 1 | Low-byte read strobe, latches high shadow |
| val_lo | output | 8 | Low byte of count or capture value |
| val_hi | output | 8 | High-byte shadow |
| tmr_evt | output | 1 | One-cycle event pulse to the flag logic |

## Verification
A wrong divider tap or a wrong select decode shows on `val_lo` within 2^code cycles of enabling, as a count step in the wrong cycle. A lost or extra event appears on `tmr_evt` in the cycle after the overflow or capture edge. A corrupted write buffer or reload value shows at the next high-byte write or the next overflow. A miscounted synchronizer depth shifts the capture result or the event by whole cycles, and a bench model that steps with every clock edge catches that in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned TMR_BYTE_W  = 8;
   localparam int unsigned TMR_N_RATES = 7;

   typedef enum logic {
      MODE_TIMER   = 1'b0,
      MODE_CAPTURE = 1'b1
   } tmr_mode_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [SYNC_STAGES-1:0] chain;
   logic                   prev;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("tmr_edge_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[SYNC_STAGES-2:0], async_in};
         prev  <= chain[SYNC_STAGES-1];
      end
   end

   assign rise = chain[SYNC_STAGES-1] & ~prev;

   // R9: a detected edge lasts a single cycle
   a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/tmr_rate_gen.sv
module tmr_rate_gen #(
   parameter int unsigned N_RATES = 7,
   parameter int unsigned SEL_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   input  logic             ext_rise,
   output logic             tick
);
   localparam int unsigned PRE_W = (N_RATES > 1) ? N_RATES - 1 : 1;

   logic [PRE_W-1:0]   pre;
   logic [N_RATES-1:0] tap;

   generate
      if (N_RATES + 1 > (1 << SEL_W)) begin : g_bad_sel
         $error("tmr_rate_gen: SEL_W too narrow for N_RATES plus the external source");
      end
      for (genvar k = 0; k < N_RATES; k++) begin : g_tap
         if (k == 0) begin : g_full
            assign tap[k] = 1'b1;
         end else begin : g_div
            assign tap[k] = &pre[k-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   pre <= '0;
      else if (en)  pre <= pre + 1'b1;
      else          pre <= '0;
   end

   always_comb begin
      if (!en)                          tick = 1'b0;
      else if (32'(sel) < N_RATES)      tick = tap[sel];
      else                              tick = ext_rise;
   end

   // R5: nothing steps while disabled
   a_r5_no_tick_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !tick);
   // R2: divided rates never step on two consecutive cycles
   a_r2_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel >= 1 && 32'(sel) < N_RATES) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             cap_mode,
   input  logic             ext_rise,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap,
   output logic             evt
);
   logic [CNT_W-1:0] reload;
   logic             wrap;
   logic             do_cap;

   assign wrap   = &cnt;
   assign do_cap = en & cap_mode & ext_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         cap    <= '0;
         reload <= '0;
         evt    <= 1'b0;
      end else begin
         if (load) begin
            cnt    <= load_val;
            reload <= load_val;
         end else if (tick) begin
            cnt <= wrap ? reload : cnt + 1'b1;
         end
         if (do_cap) cap <= cnt;
         evt <= do_cap | (tick & ~load & wrap & ~cap_mode);
      end
   end

   // R3: overflow in timer mode reloads and signals
   a_r3_overflow_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && !cap_mode && wrap) |=> (evt && cnt == $past(reload)));
   // R4: capture takes the prior count and signals
   a_r4_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cap_mode && ext_rise) |=> (evt && cap == $past(cnt)));
   // R5: frozen while disabled
   a_r5_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> ($stable(cnt) && $stable(cap) && !evt));
   // R6: a write wins over a step
   a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(load_val));
endmodule

// File: rtl/sel_clk_timer.sv
module sel_clk_timer
   import tmr_pkg::*;
#(
   parameter int unsigned BYTE_W  = TMR_BYTE_W,
   parameter int unsigned N_RATES = TMR_N_RATES,
   parameter int unsigned SEL_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic [SEL_W-1:0]  clk_sel,
   input  logic              cap_mode,
   input  logic              cmp_in,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_lo,
   output logic [BYTE_W-1:0] val_lo,
   output logic [BYTE_W-1:0] val_hi,
   output logic              tmr_evt
);
   localparam int unsigned CNT_W = 2 * BYTE_W;

   logic              ext_rise;
   logic              tick;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cap;
   logic [CNT_W-1:0]  sel_val;
   logic [BYTE_W-1:0] lo_buf;
   logic [BYTE_W-1:0] hi_sh;
   tmr_mode_e         mode;

   generate
      if (BYTE_W == 0) begin : g_bad_byte
         $error("sel_clk_timer: BYTE_W must be non-zero");
      end
   endgenerate

   assign mode = tmr_mode_e'(cap_mode);

   tmr_edge_sync #(.SYNC_STAGES(2)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (cmp_in),
      .rise     (ext_rise)
   );

   tmr_rate_gen #(.N_RATES(N_RATES), .SEL_W(SEL_W)) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (run_en),
      .sel      (clk_sel),
      .ext_rise (ext_rise),
      .tick     (tick)
   );

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (run_en),
      .tick     (tick),
      .cap_mode (mode == MODE_CAPTURE),
      .ext_rise (ext_rise),
      .load     (wr_hi),
      .load_val ({wr_data, lo_buf}),
      .cnt      (cnt),
      .cap      (cap),
      .evt      (tmr_evt)
   );

   assign sel_val = (mode == MODE_CAPTURE) ? cap : cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_buf <= '0;
         hi_sh  <= '0;
      end else begin
         if (wr_lo) lo_buf <= wr_data;
         if (rd_lo) hi_sh  <= sel_val[CNT_W-1:BYTE_W];
      end
   end

   assign val_lo = sel_val[BYTE_W-1:0];
   assign val_hi = hi_sh;

   // R8: shadow only moves on a low-byte read
   a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_lo |=> $stable(val_hi));
   // R6: a low-byte write alone leaves the count alone
   a_r6_lo_buffered: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi && !tick) |=> cnt == $past(cnt));
endmodule

// File: tb/sel_clk_timer_test.sv
`timescale 1ns/1ps
module sel_clk_timer_test;
   logic       clk = 1'b0;
   logic       rst_n, run_en, cap_mode, cmp_in, wr_lo, wr_hi, rd_lo;
   logic [2:0] clk_sel;
   logic [7:0] wr_data;
   logic [7:0] val_lo, val_hi;
   logic       tmr_evt;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // bench model state
   logic [15:0] m_cnt, m_rel, m_cap;
   logic [7:0]  m_lob, m_sh;
   logic [5:0]  m_pre;
   logic        m_evt, c1, c2, c3;

   always #4 clk = ~clk;

   sel_clk_timer uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .clk_sel(clk_sel),
      .cap_mode(cap_mode), .cmp_in(cmp_in), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .wr_data(wr_data), .rd_lo(rd_lo), .val_lo(val_lo), .val_hi(val_hi),
      .tmr_evt(tmr_evt)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic step_due(input logic [2:0] s, input logic [5:0] pre, input logic rise);
      logic [5:0] msk;
      if (s == 3'd7) return rise;
      msk = 6'((7'd1 << s) - 7'd1);
      return (pre & msk) == msk;
   endfunction

   task automatic model_edge();
      logic rise, tk, ev;
      logic [15:0] old_cnt, old_cap;
      rise = c2 & ~c3;
      old_cnt = m_cnt; old_cap = m_cap;
      tk = run_en && step_due(clk_sel, m_pre, rise);
      ev = 1'b0;
      if (wr_hi) begin
         m_cnt = {wr_data, m_lob};
         m_rel = {wr_data, m_lob};
      end else if (tk) begin
         if (old_cnt == 16'hFFFF) begin
            m_cnt = m_rel;
            if (!cap_mode) ev = 1'b1;
         end else m_cnt = old_cnt + 16'd1;
      end
      if (run_en && cap_mode && rise) begin
         m_cap = old_cnt;
         ev = 1'b1;
      end
      if (wr_lo) m_lob = wr_data;
      if (rd_lo) m_sh = cap_mode ? old_cap[15:8] : old_cnt[15:8];
      m_pre = run_en ? m_pre + 6'd1 : 6'd0;
      c3 = c2; c2 = c1; c1 = cmp_in;
      m_evt = ev;
   endtask

   task automatic cyc();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      wr_lo = 1'b0; wr_hi = 1'b0; rd_lo = 1'b0;
      chk("R3/R4 evt", {15'd0, tmr_evt}, {15'd0, m_evt});
      chk("R7 val_lo", {8'd0, val_lo}, {8'd0, cap_mode ? m_cap[7:0] : m_cnt[7:0]});
      chk("R8 val_hi", {8'd0, val_hi}, {8'd0, m_sh});
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] snap;
      void'($urandom(32'd1234));
      rst_n = 0; run_en = 0; cap_mode = 0; cmp_in = 0; wr_lo = 0; wr_hi = 0;
      rd_lo = 0; clk_sel = 0; wr_data = 0;
      m_cnt = 0; m_rel = 0; m_cap = 0; m_lob = 0; m_sh = 0; m_pre = 0;
      m_evt = 0; c1 = 0; c2 = 0; c3 = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 val_lo", {8'd0, val_lo}, 16'd0);
      chk("R1 val_hi", {8'd0, val_hi}, 16'd0);
      chk("R1 evt", {15'd0, tmr_evt}, 16'd0);

      // R2: code 3 steps every 8 cycles, first at the 8th enabled edge
      run_en = 1; clk_sel = 3'd3;
      repeat (7) cyc();
      chk("R2 before 8th", {8'd0, val_lo}, 16'd0);
      cyc();
      chk("R2 at 8th", {8'd0, val_lo}, 16'd1);
      repeat (8) cyc();
      chk("R2 second step", {8'd0, val_lo}, 16'd2);

      // R5: disabled holds
      run_en = 0; clk_sel = 3'd0;
      repeat (20) cyc();
      chk("R5 frozen", {8'd0, val_lo}, 16'd2);

      // R6: low write buffered, high write commits
      wr_lo = 1; wr_data = 8'hFE; cyc();
      chk("R6 lo held", {8'd0, val_lo}, 16'd2);
      wr_hi = 1; wr_data = 8'hFF; cyc();
      chk("R6 committed", {8'd0, val_lo}, 16'h00FE);
      run_en = 1; cyc();
      chk("R6 step", {8'd0, val_lo}, 16'h00FF);
      cyc();
      // R3: overflow reloads FFFE and pulses
      chk("R3 reload", {8'd0, val_lo}, 16'h00FE);
      chk("R3 evt", {15'd0, tmr_evt}, 16'd1);
      cyc();
      chk("R3 evt single", {15'd0, tmr_evt}, 16'd0);

      // R8 coherent read of high byte
      rd_lo = 1; cyc();
      chk("R8 shadow", {8'd0, val_hi}, 16'h00FF);

      // R9/R4: comparator edge captured at the third edge
      cap_mode = 1; repeat (3) cyc();
      cmp_in = 1; cyc(); cyc();
      chk("R9 not yet", {15'd0, tmr_evt}, 16'd0);
      snap = m_cnt[7:0];
      cyc();
      chk("R9 evt at edge 3", {15'd0, tmr_evt}, 16'd1);
      chk("R4 captured", {8'd0, val_lo}, {8'd0, snap});
      cmp_in = 0;

      // R2 code 7 counts comparator edges
      cap_mode = 0; clk_sel = 3'd7; repeat (4) cyc();
      snap = val_lo;
      cmp_in = 1; repeat (3) cyc();
      chk("R2 ext step", {8'd0, val_lo}, {8'd0, snap + 8'd1});
      cmp_in = 0;

      // random phase
      for (int i = 0; i < 4000; i++) begin
         run_en   = ($urandom % 10) != 0;
         if (($urandom % 40) == 0) clk_sel  = 3'($urandom);
         if (($urandom % 60) == 0) cap_mode = ~cap_mode;
         if (($urandom % 4) == 0)  cmp_in   = ~cmp_in;
         wr_data = 8'($urandom);
         wr_lo = ($urandom % 30) == 0;
         wr_hi = ($urandom % 50) == 0;
         if (($urandom % 3) == 0) wr_data = 8'hFF;
         rd_lo = ($urandom % 5) == 0;
         cyc();
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule